// File: doc/BRIEF.md
# Event-to-DMA Trigger Router

The router sits between a set of hardware event sources (timers, a serial receiver) and two consumers: a four-channel DMA engine and an interrupt controller. Each event lane delivers a one-cycle pulse. Every lane has a fixed 8-bit event code and a fixed interrupt source index, both set by parameters. Software programs four byte-wide start-vector registers over a small write-only register bus. Each register belongs to one DMA channel.

When an event is serviced, its code is compared with the four vectors. Channel 0 has the highest precedence and channel 3 the lowest. The first matching channel receives a one-cycle start strobe, and that event raises no interrupt. If no vector matches, the router issues a one-cycle interrupt-set strobe carrying the lane's source index.

Events that collide in one cycle are serviced one per cycle, lowest lane first. The others wait in a per-lane pending bit.

Top module: `evt_dma_router`

## Requirements
- R1: The vector registers sit at bus addresses VEC_BASE+0 to VEC_BASE+3, which are 0x7C to 0x7F by default, for DMA channels 0 to 3. A cycle with `bus_we` high loads `bus_wdata` into the addressed register.
- R2: A synchronous active-low reset clears all four vectors to 0x00, clears every pending event and holds both strobes low.
- R3: A serviced event whose code equals the vector of some channel produces `dma_go`=1 with `dma_ch` set to that channel for exactly one cycle. The strobe appears in the cycle after the event is taken, and `irq_set` stays 0.
- R4: When several channels hold the event's code, only the lowest-numbered matching channel is started.
- R5: A serviced event that matches no vector produces `irq_set`=1 with `irq_src` equal to the lane's source index for one cycle, and `dma_go` stays 0.
- R6: Pulses that arrive together are serviced one per cycle, lowest lane index first. Lanes are wired in ascending source-index order. Each waiting lane is serviced in a following cycle and none is lost.
- R7: `dma_go` and `irq_set` are never high together. Each serviced event yields exactly one strobe cycle. With nothing pending, both strobes stay low.
- R8: A bus write to any address outside the four vector addresses changes no vector.
- R9: The default lane map is as follows. Lanes 0 to 3 carry codes 0x10 to 0x13 and sources 7 to 10. Lane 4 carries code 0x19 and source 12.
- R10: The comparison uses the vector values held at the moment of service. A write in the same cycle as a pulse affects only events serviced afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | LANES (5) | One-cycle event pulse per lane |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | ADDR_W (8) | Register write address |
| bus_wdata | input | 8 | Register write data |
| dma_go | output | 1 | One-cycle DMA start strobe |
| dma_ch | output | 2 | Channel to start, valid with dma_go |
| irq_set | output | 1 | One-cycle interrupt-set strobe |
| irq_src | output | 5 | Source index to set pending, valid with irq_set |

## Verification
The bench targets the following corner cases, each paired with the faulty behaviour it would expose:
- Several channels programmed with the same code: a router with the wrong precedence starts channel 1 or 3 instead of the lowest match.
- All five lanes fired at once: a broken hold stage drops or reorders the waiting events, or two strobes come out together.
- A vector write landing in the same cycle as a pulse: a design that compares against the new value starts DMA one event too early.
- Writes to neighbouring addresses 0x7B and 0x80: a loose decode would let these divert an event that should have raised an interrupt.

// File: rtl/evtr_pkg.sv
// Package: shared widths and helper for the event-to-DMA router.
// Assumes byte-wide vectors and event codes, 5-bit interrupt source indices.
package evtr_pkg;
    localparam int CODE_W = 8;
    localparam int SRC_W  = 5;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SRC_W-1:0]  src_t;

    // Isolate the lowest set bit of a request vector.
    function automatic logic [31:0] lowest_bit(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction
endpackage

// File: rtl/evtr_arbiter.sv
// Module: evtr_arbiter
// Holds one pending bit per event lane and grants the lowest-numbered
// requesting lane each cycle (new pulse or held). Assumes lanes are wired in
// ascending interrupt-source order; a pulse on an already pending lane merges.
module evtr_arbiter #(
    parameter int LANES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] evt_pulse,
    output logic [LANES-1:0] grant,
    output logic             any_req
);
    import evtr_pkg::*;

    logic [LANES-1:0] pend_q;
    logic [LANES-1:0] req;
    logic [31:0]      req_wide;
    logic [31:0]      low_wide;

    // Combine held and fresh requests, pick the lowest lane.
    always_comb begin
        req      = pend_q | evt_pulse;
        req_wide = 32'(req);
        low_wide = lowest_bit(req_wide);
        grant    = low_wide[LANES-1:0];
        any_req  = |req;
    end

    // Keep every request that was not granted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= req & ~grant;
    end

    // R6: a grant never covers two lanes at once.
    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: when requests collide, the losers remain pending next cycle.
    assert_hold_losers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) > 1) |=> (pend_q != '0));
endmodule

// File: rtl/evtr_vec_regs.sv
// Module: evtr_vec_regs
// Byte-wide start-vector registers, one per DMA channel, at consecutive
// addresses from VEC_BASE. Write-only bus; other addresses are ignored.
module evtr_vec_regs #(
    parameter int              CH_N     = 4,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 8'h7C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [CH_N*8-1:0]   vec_flat
);
    for (genvar k = 0; k < CH_N; k++) begin : g_vec
        localparam logic [ADDR_W-1:0] MY_ADDR = VEC_BASE + ADDR_W'(k);
        logic [7:0] vec_q;

        // Load this channel's vector on an address match; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                             vec_q <= 8'h00;
            else if (bus_we && bus_addr == MY_ADDR) vec_q <= bus_wdata;
        end

        assign vec_flat[k*8 +: 8] = vec_q;

        // R1: a write to this channel's address is visible in the next cycle.
        assert_vec_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == MY_ADDR) |=> (vec_flat[k*8 +: 8] == $past(bus_wdata)));

        // R8: without a write to this address the vector is unchanged.
        assert_vec_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_we && bus_addr == MY_ADDR) |=> $stable(vec_flat[k*8 +: 8]));
    end
endmodule

// File: rtl/evtr_vec_match.sv
// Module: evtr_vec_match
// Compares one event code with every channel vector and reports the
// lowest-numbered channel that matches. Purely combinational.
module evtr_vec_match #(
    parameter int CH_N = 4,
    localparam int CH_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
    input  logic [CH_N*8-1:0] vec_flat,
    input  logic [7:0]        code,
    output logic              hit,
    output logic [CH_W-1:0]   ch
);
    logic [CH_N-1:0] match;

    for (genvar k = 0; k < CH_N; k++) begin : g_cmp
        assign match[k] = (vec_flat[k*8 +: 8] == code);
    end

    // Priority encode: scan from the top so the lowest match wins.
    always_comb begin
        ch  = '0;
        hit = |match;
        for (int k = CH_N - 1; k >= 0; k--) begin
            if (match[k]) ch = CH_W'(k);
        end
    end

    // R4: a reported channel holds the code and no lower channel does.
    always_comb begin
        if (hit) begin
            assert_first_hit_R4: assert ((vec_flat[ch*8 +: 8] == code) &&
                ((match & ((CH_N'(1) << ch) - CH_N'(1))) == '0));
        end
    end
endmodule

// File: rtl/evt_dma_router.sv
// Module: evt_dma_router (top)
// Routes event pulses either to a DMA channel start or to an interrupt-set
// strobe. Lane codes and source indices are fixed by parameters. Outputs are
// registered: a strobe appears the cycle after its event is serviced.
module evt_dma_router #(
    parameter int                 LANES     = 5,
    parameter int                 CH_N      = 4,
    parameter int                 ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  VEC_BASE  = 8'h7C,
    parameter logic [LANES*8-1:0] LANE_CODE = {8'h19, 8'h13, 8'h12, 8'h11, 8'h10},
    parameter logic [LANES*5-1:0] LANE_SRC  = {5'd12, 5'd10, 5'd9, 5'd8, 5'd7},
    localparam int                CH_W      = (CH_N > 1) ? $clog2(CH_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  evt_pulse,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              dma_go,
    output logic [CH_W-1:0]   dma_ch,
    output logic              irq_set,
    output logic [4:0]        irq_src
);
    import evtr_pkg::*;

    logic [LANES-1:0]  grant;
    logic              any_req;
    logic [CH_N*8-1:0] vec_flat;
    code_t             sel_code;
    src_t              sel_src;
    logic              hit;
    logic [CH_W-1:0]   hit_ch;

    evtr_arbiter #(.LANES(LANES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .grant     (grant),
        .any_req   (any_req)
    );

    evtr_vec_regs #(.CH_N(CH_N), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .vec_flat  (vec_flat)
    );

    // Select the code and source of the granted lane (grant is one-hot).
    always_comb begin
        sel_code = '0;
        sel_src  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (grant[i]) begin
                sel_code = LANE_CODE[i*8 +: 8];
                sel_src  = LANE_SRC[i*5 +: 5];
            end
        end
    end

    evtr_vec_match #(.CH_N(CH_N)) u_match (
        .vec_flat (vec_flat),
        .code     (sel_code),
        .hit      (hit),
        .ch       (hit_ch)
    );

    // Register the routing decision into the two exclusive strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_go  <= 1'b0;
            dma_ch  <= '0;
            irq_set <= 1'b0;
            irq_src <= '0;
        end else begin
            dma_go  <= any_req && hit;
            dma_ch  <= (any_req && hit) ? hit_ch : '0;
            irq_set <= any_req && !hit;
            irq_src <= (any_req && !hit) ? sel_src : '0;
        end
    end

    // R7: the two strobes never overlap.
    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_go && irq_set));

    // R7: a strobe only follows a cycle in which a request was serviced.
    assert_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_go || irq_set) |-> $past(any_req));

    // R5: an interrupt is set only when no vector matched.
    assert_irq_nomatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |-> $past(!hit));

    // R3: a DMA start follows a vector match on the serviced event.
    assert_dma_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_go |-> $past(hit && any_req));
endmodule

// File: tb/sim_evt_dma_router.sv
// Bench for evt_dma_router: directed corner cases then seeded random traffic,
// compared each cycle against a model built from the requirements.
module sim_evt_dma_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] evt_pulse = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       dma_go;
    logic [1:0] dma_ch;
    logic       irq_set;
    logic [4:0] irq_src;

    int n_vec  = 0;
    int n_fail = 0;

    logic [4:0] m_pend;
    logic [7:0] m_vec [4];
    logic       e_go, e_irq;
    logic [1:0] e_ch;
    logic [4:0] e_src;
    string      e_tag;

    always #10 clk = ~clk;

    evt_dma_router u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .dma_go(dma_go), .dma_ch(dma_ch), .irq_set(irq_set), .irq_src(irq_src)
    );

    // R9 lane map
    function automatic logic [7:0] lane_code(int i);
        return (i == 4) ? 8'h19 : 8'(8'h10 + i);
    endfunction
    function automatic logic [4:0] lane_src(int i);
        return (i == 4) ? 5'd12 : 5'(7 + i);
    endfunction

    task automatic check_out(string tag);
        n_vec++;
        if (dma_go !== e_go || irq_set !== e_irq ||
            (e_go && dma_ch !== e_ch) || (e_irq && irq_src !== e_src)) begin
            n_fail++;
            $display("FAIL %s: got go=%0b ch=%0d irq=%0b src=%0d, expected go=%0b ch=%0d irq=%0b src=%0d",
                     tag, dma_go, dma_ch, irq_set, irq_src, e_go, e_ch, e_irq, e_src);
        end
    endtask

    // One cycle: drive at negedge, predict, then compare at the next negedge.
    task automatic step(logic [4:0] p, logic we, logic [7:0] a, logic [7:0] d, string tag);
        logic [4:0] req;
        evt_pulse = p; bus_we = we; bus_addr = a; bus_wdata = d;
        req = m_pend | p;
        e_go = 0; e_irq = 0; e_ch = 0; e_src = 0;
        if (req != 0) begin
            int lane = 0;
            int ch = -1;
            for (int i = 4; i >= 0; i--) if (req[i]) lane = i;
            for (int c = 3; c >= 0; c--) if (m_vec[c] == lane_code(lane)) ch = c;
            if (ch >= 0) begin e_go = 1; e_ch = 2'(ch); end
            else begin e_irq = 1; e_src = lane_src(lane); end
            m_pend = req & ~(5'd1 << lane);
        end
        if (we && a >= 8'h7C && a <= 8'h7F) m_vec[a - 8'h7C] = d;
        e_tag = (tag != "") ? tag : (e_go ? "R3" : (e_irq ? "R5" : "R7"));
        @(negedge clk);
        check_out(e_tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(5'd0, 1'b0, 8'h00, 8'h00, tag);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        m_pend = '0;
        for (int c = 0; c < 4; c++) m_vec[c] = 8'h00;
        e_go = 0; e_irq = 0; e_ch = 0; e_src = 0;
        repeat (3) @(negedge clk);
        check_out("R2 reset");
        rst_n = 1'b1;
        idle(2, "R2 idle after reset");
        // R2: vectors cleared, so timer 0 raises source 7
        step(5'b00001, 0, 8'h00, 8'h00, "R2 vectors clear -> irq");
        idle(1, "R7 single strobe");
        // R1 R3: program channel 0 for timer 0
        step(5'd0, 1, 8'h7C, 8'h10, "R1 write");
        step(5'b00001, 0, 8'h00, 8'h00, "R3 dma ch0");
        idle(1, "R7 single strobe");
        // R4: channels 0 and 1 both hold 0x10
        step(5'd0, 1, 8'h7D, 8'h10, "R1 write");
        step(5'b00001, 0, 8'h00, 8'h00, "R4 lowest channel");
        idle(1, "R7");
        step(5'd0, 1, 8'h7C, 8'h00, "R1 write");
        step(5'b00001, 0, 8'h00, 8'h00, "R4 next channel");
        idle(1, "R7");
        // R8: neighbouring addresses do not load vectors
        step(5'd0, 1, 8'h7B, 8'h19, "R8 write below");
        step(5'd0, 1, 8'h80, 8'h19, "R8 write above");
        step(5'b10000, 0, 8'h00, 8'h00, "R8 serial still irq");
        idle(1, "R7");
        // R6: all lanes at once
        step(5'd0, 1, 8'h7F, 8'h12, "R1 write");
        step(5'b11111, 0, 8'h00, 8'h00, "R6 burst lane0");
        idle(4, "R6 burst drain");
        idle(1, "R7 quiet after burst");
        // R10: write and pulse in the same cycle use the old vector
        step(5'b01000, 1, 8'h7E, 8'h13, "R10 old vector");
        step(5'b01000, 0, 8'h00, 8'h00, "R10 new vector");
        idle(1, "R7");
        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [4:0] p;
            logic       we;
            logic [7:0] a, d;
            p  = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
            we = ($urandom % 4 == 0);
            a  = 8'(8'h7A + $urandom % 7);
            case ($urandom % 6)
                0: d = 8'h10; 1: d = 8'h11; 2: d = 8'h12;
                3: d = 8'h13; 4: d = 8'h19; default: d = 8'($urandom);
            endcase
            step(p, we, a, d, "");
        end
        idle(8, "R6 drain");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule